// File: doc/BRIEF.md
# Flash Command Decoder

This block is the device side of a halfword-wide flash command interface. A host writes 16-bit command words over a simple synchronous bus. The block decodes them with a small sequencer. Some commands take effect on a single write. Others need a setup word followed by a confirm or data word. The sequencer selects what reads return: stored halfwords, a status byte, or a bitmap that shows which sectors are locked. It also carries out erase, program and lock changes on a small behavioural cell array. Each of these operations keeps the device busy for a fixed number of clock cycles.

The cell array is organised as a group of large sectors followed by a group of small sectors, with a fixed number of halfwords in each sector. The sector counts and the halfwords per sector are parameters. A halfword address is `{sector index, word index}`, with the word index in the low bits. Every sector comes out of reset locked, so software must unlock a sector before it can erase or program it. A write to a locked sector changes nothing in the array and sets error flags, which software can then read from the status byte.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the block is in array-read mode, every cell holds 0xFFFF, every sector is locked, and the status byte is 0x80.
- R2: Writing 0x00FF selects array-read mode. Reads then return the halfword at `bus_addr`, where bits [ADDR_W-1:2] give the sector and bits [1:0] give the word (default geometry). A sector index at or above the sector count reads as 0xFFFF.
- R3: Writing 0x0070 selects status mode. Reads then return the status byte in bits [7:0] and zero in bits [15:8]. In the status byte, bit 7 is ready, bit 5 is erase error, bit 4 is program error and bit 1 is protection error. All other bits read 0.
- R4: Writing 0x0050 clears status bits 5, 4 and 1 and does not change the read mode.
- R5: Writing 0x0020 and then 0x00D0 to an unlocked sector sets every halfword of that sector to 0xFFFF. Other sectors do not change.
- R6: Writing 0x0040 and then a data word stores (old AND data) at the write address. If the data has a 1 where the old value has a 0, status bit 4 is set.
- R7: Writing 0x0060 and then 0x0001 locks the sector of the write address. Writing 0x0060 and then 0x00D0 unlocks it.
- R8: Writing 0x0090 selects protection mode. Reads then return a bitmap in which bit i is 1 when sector i is locked. The large sectors come first (bits 0 to NUM_LARGE-1) and the small sectors follow. Unused upper bits read 0.
- R9: An accepted erase holds status bit 7 at 0 for exactly ERASE_CYCLES cycles, starting with the cycle after the confirm write. An accepted program or lock change does the same for PROG_CYCLES cycles. Writes made during this time are ignored.
- R10: An erase or program aimed at a locked sector, or at a sector index beyond the last sector, leaves the array unchanged. It sets bit 1 together with bit 5 (erase) or bit 4 (program), and the device does not go busy.
- R11: After 0x0020 or 0x0060, a second write that is not a valid confirm sets bits 5 and 4. It changes neither the array nor the locks, and the block goes back to idle in status mode.
- R12: Writing 0x0020, 0x0040 or 0x0060 switches reads to status mode at once, and the block stays in status mode after the operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe; a write takes effect on the rising edge |
| bus_addr | input | ADDR_W (6) | Halfword address `{sector, word}` |
| bus_wdata | input | 16 | Command or data word |
| bus_rdata | output | 16 | Read data, combinational from mode and address |

## Verification
Reads are combinational, so a mode change or a cell update from a write is visible in the cycle after the edge that takes the write. The bench drives on the falling edge and samples a few nanoseconds later, so each result is read in the first cycle it is due. A busy period starts in the cycle after the confirm write's edge. The bench counts the cycles in which bit 7 reads 0 and compares that count with ERASE_CYCLES or PROG_CYCLES. A behavioural model advances on every rising edge and predicts `bus_rdata` for every cycle, so a result that appears one cycle early or late is caught.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
// Package: shared command codes, read modes, sequencer states and the
// operation / error pulse records passed between the decoder sub-blocks.
package flash_cmd_pkg;

    localparam logic [15:0] CMD_READ_ARRAY  = 16'h00FF;
    localparam logic [15:0] CMD_READ_STATUS = 16'h0070;
    localparam logic [15:0] CMD_CLEAR_ERR   = 16'h0050;
    localparam logic [15:0] CMD_READ_LOCKS  = 16'h0090;
    localparam logic [15:0] CMD_ERASE_SETUP = 16'h0020;
    localparam logic [15:0] CMD_PROG_SETUP  = 16'h0040;
    localparam logic [15:0] CMD_LOCK_SETUP  = 16'h0060;
    localparam logic [15:0] CMD_CONFIRM     = 16'h00D0;
    localparam logic [15:0] CMD_LOCK_SET    = 16'h0001;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_LOCKS  = 2'd2
    } read_mode_e;

    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_ERASE_ARM = 3'd1,
        SEQ_PROG_ARM  = 3'd2,
        SEQ_LOCK_ARM  = 3'd3,
        SEQ_BUSY      = 3'd4
    } seq_state_e;

    // One-cycle operation pulses applied to the cell array.
    typedef struct packed {
        logic erase;
        logic prog;
        logic lock_set;
        logic lock_clr;
    } op_t;

    // One-cycle error-set pulses applied to the status register.
    typedef struct packed {
        logic erase;
        logic prog;
        logic prot;
    } err_t;

endpackage

// File: rtl/fcu_sequencer.sv
`timescale 1ns/1ps
// Module: fcu_sequencer
// Decodes bus writes into read-mode changes and array operations, runs the
// two-write setup/confirm handshake and times the busy window.
// Assumes: sec_locked_i / would_set_i describe the addressed sector and cell
// in the same cycle as the write; ERASE_CYCLES and PROG_CYCLES are >= 1.
module fcu_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ERASE_CYCLES = 24,
    parameter int PROG_CYCLES  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    input  logic        sec_locked_i,
    input  logic        would_set_i,
    output read_mode_e  mode_o,
    output logic        ready_o,
    output op_t         op_o,
    output err_t        err_set_o,
    output logic        err_clr_o
);
    localparam int CNT_MAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);

    seq_state_e       state_q, state_d;
    read_mode_e       mode_q, mode_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state decode of the command stream and busy countdown.
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        cnt_d     = cnt_q;
        op_o      = '0;
        err_set_o = '0;
        err_clr_o = 1'b0;
        unique case (state_q)
            SEQ_BUSY: begin
                if (cnt_q == '0) state_d = SEQ_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            SEQ_IDLE: begin
                if (wr_en_i) begin
                    unique case (wr_data_i)
                        CMD_READ_ARRAY:  mode_d = MODE_ARRAY;
                        CMD_READ_STATUS: mode_d = MODE_STATUS;
                        CMD_READ_LOCKS:  mode_d = MODE_LOCKS;
                        CMD_CLEAR_ERR:   err_clr_o = 1'b1;
                        CMD_ERASE_SETUP: begin state_d = SEQ_ERASE_ARM; mode_d = MODE_STATUS; end
                        CMD_PROG_SETUP:  begin state_d = SEQ_PROG_ARM;  mode_d = MODE_STATUS; end
                        CMD_LOCK_SETUP:  begin state_d = SEQ_LOCK_ARM;  mode_d = MODE_STATUS; end
                        default: ;
                    endcase
                end
            end
            SEQ_ERASE_ARM: begin
                if (wr_en_i) begin
                    state_d = SEQ_IDLE;
                    mode_d  = MODE_STATUS;
                    if (wr_data_i != CMD_CONFIRM) begin
                        err_set_o.erase = 1'b1;
                        err_set_o.prog  = 1'b1;
                    end else if (sec_locked_i) begin
                        err_set_o.erase = 1'b1;
                        err_set_o.prot  = 1'b1;
                    end else begin
                        op_o.erase = 1'b1;
                        state_d    = SEQ_BUSY;
                        cnt_d      = ERASE_LOAD;
                    end
                end
            end
            SEQ_PROG_ARM: begin
                if (wr_en_i) begin
                    state_d = SEQ_IDLE;
                    mode_d  = MODE_STATUS;
                    if (sec_locked_i) begin
                        err_set_o.prog = 1'b1;
                        err_set_o.prot = 1'b1;
                    end else begin
                        op_o.prog      = 1'b1;
                        err_set_o.prog = would_set_i;
                        state_d        = SEQ_BUSY;
                        cnt_d          = PROG_LOAD;
                    end
                end
            end
            SEQ_LOCK_ARM: begin
                if (wr_en_i) begin
                    state_d = SEQ_IDLE;
                    mode_d  = MODE_STATUS;
                    if (wr_data_i == CMD_LOCK_SET) begin
                        op_o.lock_set = 1'b1;
                        state_d       = SEQ_BUSY;
                        cnt_d         = PROG_LOAD;
                    end else if (wr_data_i == CMD_CONFIRM) begin
                        op_o.lock_clr = 1'b1;
                        state_d       = SEQ_BUSY;
                        cnt_d         = PROG_LOAD;
                    end else begin
                        err_set_o.erase = 1'b1;
                        err_set_o.prog  = 1'b1;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State, read-mode and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            mode_q  <= MODE_ARRAY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            cnt_q   <= cnt_d;
        end
    end

    assign mode_o  = mode_q;
    assign ready_o = (state_q != SEQ_BUSY);

    assert_one_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_o));
    assert_op_goes_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o != '0) |=> !ready_o);
    assert_busy_ignores_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ready_o) |=> $stable(mode_o));
    assert_confirm_to_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (state_q == SEQ_ERASE_ARM || state_q == SEQ_LOCK_ARM)) |=> mode_o == MODE_STATUS);

endmodule

// File: rtl/fcu_status_reg.sv
`timescale 1ns/1ps
// Module: fcu_status_reg
// Holds the three sticky error flags and assembles the status byte.
// Assumes: set and clear pulses never arrive in the same cycle.
module fcu_status_reg
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_i,
    input  err_t       err_set_i,
    input  logic       err_clr_i,
    output logic [7:0] status_o
);
    err_t err_q;

    // Sticky error flags: set by pulses, cleared by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= '0;
        else if (err_clr_i) err_q <= '0;
        else                err_q <= err_q | err_set_i;
    end

    assign status_o = {ready_i, 1'b0, err_q.erase, err_q.prog, 2'b00, err_q.prot, 1'b0};

    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> (status_o[5:4] == 2'b00 && !status_o[1]));

endmodule

// File: rtl/fcu_cell_array.sv
`timescale 1ns/1ps
// Module: fcu_cell_array
// Behavioural halfword storage split into sectors, plus one lock bit per
// sector. Applies erase / program / lock pulses on the clock edge.
// Assumes: WORDS_PER_SECTOR is a power of two >= 2; sector indices at or
// beyond NUM_SECTORS are treated as locked and read as 0xFFFF.
module fcu_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int NUM_SECTORS      = 12,
    parameter int WORDS_PER_SECTOR = 4,
    parameter int ADDR_W           = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [15:0]            wdata_i,
    input  op_t                    op_i,
    output logic [15:0]            rd_word_o,
    output logic [NUM_SECTORS-1:0] lock_map_o,
    output logic                   sec_locked_o,
    output logic                   would_set_o
);
    localparam int WORD_W = $clog2(WORDS_PER_SECTOR);
    localparam int SEC_W  = ADDR_W - WORD_W;

    logic [SEC_W-1:0]  sec_idx;
    logic [WORD_W-1:0] word_idx;
    logic              sec_valid;
    logic [WORDS_PER_SECTOR-1:0][15:0] sec_bus [NUM_SECTORS];

    assign sec_idx   = addr_i[ADDR_W-1:WORD_W];
    assign word_idx  = addr_i[WORD_W-1:0];
    assign sec_valid = (int'(sec_idx) < NUM_SECTORS);

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
        logic [WORDS_PER_SECTOR-1:0][15:0] words_q;
        logic                              lock_q;
        logic                              hit;

        assign hit = (sec_idx == SEC_W'(s));

        // Cell contents of one sector: erase to all ones, program by AND.
        always_ff @(posedge clk) begin
            if (!rst_n)                    words_q <= '1;
            else if (op_i.erase && hit)    words_q <= '1;
            else if (op_i.prog && hit)     words_q[word_idx] <= words_q[word_idx] & wdata_i;
        end

        // Lock bit of one sector: locked out of reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                    lock_q <= 1'b1;
            else if (op_i.lock_set && hit) lock_q <= 1'b1;
            else if (op_i.lock_clr && hit) lock_q <= 1'b0;
        end

        assign sec_bus[s]    = words_q;
        assign lock_map_o[s] = lock_q;
    end

    assign rd_word_o    = sec_valid ? sec_bus[sec_idx][word_idx] : 16'hFFFF;
    assign sec_locked_o = !sec_valid || lock_map_o[sec_idx];
    assign would_set_o  = |(wdata_i & ~rd_word_o);

    assert_no_write_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i.erase || op_i.prog) |-> !sec_locked_o);
    assert_locks_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i.lock_set || op_i.lock_clr) |=> $stable(lock_map_o));

endmodule

// File: rtl/flash_cmd_ui.sv
`timescale 1ns/1ps
// Module: flash_cmd_ui (top)
// Flash command decoder with a synchronous write / combinational read bus.
// Connects the sequencer, status register and cell array and muxes the read
// path by the current read mode.
// Assumes: NUM_LARGE + NUM_SMALL <= 16 so the lock bitmap fits the bus.
module flash_cmd_ui
    import flash_cmd_pkg::*;
#(
    parameter int NUM_LARGE        = 8,
    parameter int NUM_SMALL        = 4,
    parameter int WORDS_PER_SECTOR = 4,
    parameter int ERASE_CYCLES     = 24,
    parameter int PROG_CYCLES      = 5,
    parameter int ADDR_W = $clog2(NUM_LARGE + NUM_SMALL) + $clog2(WORDS_PER_SECTOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata
);
    localparam int NUM_SECTORS = NUM_LARGE + NUM_SMALL;

    read_mode_e             mode;
    logic                   ready;
    op_t                    op;
    err_t                   err_set;
    logic                   err_clr;
    logic                   sec_locked;
    logic                   would_set;
    logic [15:0]            rd_word;
    logic [NUM_SECTORS-1:0] lock_map;
    logic [7:0]             status;

    fcu_sequencer #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (bus_wr),
        .wr_data_i    (bus_wdata),
        .sec_locked_i (sec_locked),
        .would_set_i  (would_set),
        .mode_o       (mode),
        .ready_o      (ready),
        .op_o         (op),
        .err_set_o    (err_set),
        .err_clr_o    (err_clr)
    );

    fcu_status_reg i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (ready),
        .err_set_i (err_set),
        .err_clr_i (err_clr),
        .status_o  (status)
    );

    fcu_cell_array #(
        .NUM_SECTORS      (NUM_SECTORS),
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .ADDR_W           (ADDR_W)
    ) i_cells (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (bus_addr),
        .wdata_i      (bus_wdata),
        .op_i         (op),
        .rd_word_o    (rd_word),
        .lock_map_o   (lock_map),
        .sec_locked_o (sec_locked),
        .would_set_o  (would_set)
    );

    // Read path: select array word, status byte or lock bitmap.
    always_comb begin
        unique case (mode)
            MODE_STATUS: bus_rdata = {8'h00, status};
            MODE_LOCKS:  bus_rdata = 16'(lock_map);
            default:     bus_rdata = rd_word;
        endcase
    end

    assert_status_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATUS) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[7] == ready));

endmodule

// File: tb/test_flash_cmd_ui.sv
`timescale 1ns/1ps
module test_flash_cmd_ui;
    localparam int NL   = 8;
    localparam int NS   = 4;
    localparam int NSEC = NL + NS;
    localparam int WPS  = 4;
    localparam int EC   = 24;
    localparam int PC   = 5;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    flash_cmd_ui #(
        .NUM_LARGE (NL), .NUM_SMALL (NS), .WORDS_PER_SECTOR (WPS),
        .ERASE_CYCLES (EC), .PROG_CYCLES (PC)
    ) i_flash_cmd_ui (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_mem [NSEC*WPS];
    bit m_lock [NSEC];
    int m_mode;   // 0 array, 1 status, 2 locks
    int m_seq;    // 0 idle, 1 erase armed, 2 program armed, 3 lock armed
    int m_busy;
    bit e_er, e_pg, e_pr;

    task automatic model_step();
        int s, w, d, old;
        bit valid, locked;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            foreach (m_lock[i]) m_lock[i] = 1'b1;
            m_mode = 0; m_seq = 0; m_busy = 0;
            e_er = 0; e_pg = 0; e_pr = 0;
        end else if (m_busy > 0) begin
            m_busy--;
        end else if (bus_wr) begin
            s = int'(bus_addr) / WPS;
            w = int'(bus_addr) % WPS;
            d = int'(bus_wdata);
            valid = (s < NSEC);
            locked = !valid || m_lock[s];
            case (m_seq)
                0: case (d)
                    'hFF: m_mode = 0;
                    'h70: m_mode = 1;
                    'h90: m_mode = 2;
                    'h50: begin e_er = 0; e_pg = 0; e_pr = 0; end
                    'h20: begin m_seq = 1; m_mode = 1; end
                    'h40: begin m_seq = 2; m_mode = 1; end
                    'h60: begin m_seq = 3; m_mode = 1; end
                    default: ;
                   endcase
                1: begin
                    m_seq = 0; m_mode = 1;
                    if (d != 'hD0) begin e_er = 1; e_pg = 1; end
                    else if (locked) begin e_er = 1; e_pr = 1; end
                    else begin
                        for (int k = 0; k < WPS; k++) m_mem[s*WPS+k] = 16'hFFFF;
                        m_busy = EC;
                    end
                end
                2: begin
                    m_seq = 0; m_mode = 1;
                    if (locked) begin e_pg = 1; e_pr = 1; end
                    else begin
                        old = m_mem[s*WPS+w];
                        if ((d & ~old & 16'hFFFF) != 0) e_pg = 1;
                        m_mem[s*WPS+w] = old & d;
                        m_busy = PC;
                    end
                end
                default: begin
                    m_seq = 0; m_mode = 1;
                    if (d == 'h01) begin if (valid) m_lock[s] = 1; m_busy = PC; end
                    else if (d == 'hD0) begin if (valid) m_lock[s] = 0; m_busy = PC; end
                    else begin e_er = 1; e_pg = 1; end
                end
            endcase
        end
    endtask

    function automatic logic [15:0] model_rdata();
        int s = int'(bus_addr) / WPS;
        logic [15:0] v = '0;
        if (m_mode == 1)
            v = {8'h00, (m_busy == 0), 1'b0, e_er, e_pg, 2'b00, e_pr, 1'b0};
        else if (m_mode == 2) begin
            for (int k = 0; k < NSEC; k++) v[k] = m_lock[k];
        end else
            v = (s < NSEC) ? 16'(m_mem[int'(bus_addr)]) : 16'hFFFF;
        return v;
    endfunction

    always @(posedge clk) model_step();

    // Per-cycle comparison against the model, away from the active edge.
    always begin
        @(negedge clk);
        #4;
        if (cmp_on) begin
            logic [15:0] exp;
            string tag;
            exp = model_rdata();
            tag = (m_mode == 1) ? "R3" : (m_mode == 2) ? "R8" : "R2";
            checks++;
            if (bus_rdata !== exp) begin
                errors++;
                $display("FAIL %s cycle compare at %0t: actual=%h expected=%h", tag, $time, bus_rdata, exp);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input int a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(a);
        #4;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    // Called right after a confirm write; counts cycles with ready low.
    task automatic wait_ready(input int exp, input string tag);
        int n = 0;
        #4;
        while (bus_rdata[7] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
            #4;
        end
        if (exp >= 0) begin
            checks++;
            if (n != exp) begin
                errors++;
                $display("FAIL %s busy length: actual=%0d expected=%0d", tag, n, exp);
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state
        look(0, 16'hFFFF, "R1");
        wr(0, 'h70); look(0, 16'h0080, "R1");
        wr(0, 'h90); look(0, 16'h0FFF, "R1");
        // R12 setup switches to status; R10 program of locked sector
        wr(1, 'h40); look(1, 16'h0080, "R12");
        wr(1, 'h1234); look(1, 16'h0092, "R10");
        wr(0, 'hFF); look(1, 16'hFFFF, "R10");
        // R4 clear keeps mode
        wr(0, 'h50); look(1, 16'hFFFF, "R4");
        wr(0, 'h70); look(0, 16'h0080, "R4");
        // R7 unlock sector 0 and small sector 9, R8 bitmap order
        wr(0, 'h60); wr(0, 'hD0); wait_ready(PC, "R9");
        wr(0, 'h90); look(0, 16'h0FFE, "R7");
        wr(36, 'h60); wr(36, 'hD0); wait_ready(PC, "R7");
        look(0, 16'h0080, "R12");
        wr(0, 'h90); look(0, 16'h0DFE, "R8");
        // R6 program by AND
        wr(1, 'h40); wr(1, 'h1234); wait_ready(PC, "R9");
        look(1, 16'h0080, "R6");
        wr(0, 'hFF); look(1, 16'h1234, "R6");
        wr(1, 'h40); wr(1, 'h0034); wait_ready(PC, "R6");
        wr(0, 'hFF); look(1, 16'h0034, "R6");
        wr(1, 'h40); wr(1, 'h00FF); wait_ready(PC, "R6");
        look(1, 16'h0090, "R6");
        wr(0, 'hFF); look(1, 16'h0034, "R6");
        wr(0, 'h50);
        wr(39, 'h40); wr(39, 'hA5A5); wait_ready(PC, "R6");
        // R9 writes during busy ignored
        wr(2, 'h40); wr(2, 'h0F0F); wr(2, 'hFF); wait_ready(-1, "R9");
        look(2, 16'h0080, "R9");
        wr(0, 'hFF); look(2, 16'h0F0F, "R9");
        // R5 erase, R9 erase busy length
        wr(0, 'h20); look(0, 16'h0080, "R12");
        wr(0, 'hD0); wait_ready(EC, "R9");
        wr(0, 'hFF); look(1, 16'hFFFF, "R5");
        look(2, 16'hFFFF, "R5");
        look(39, 16'hA5A5, "R5");
        // R10 erase of locked sector and of a nonexistent sector
        wr(4, 'h20); wr(4, 'hD0); look(4, 16'h00A2, "R10");
        wr(0, 'h50);
        wr(48, 'h40); wr(48, 'h0000); look(48, 16'h0092, "R10");
        wr(0, 'h50);
        // R11 bad confirm after erase and lock setup
        wr(0, 'h20); wr(0, 'h55); look(0, 16'h00B0, "R11");
        wr(0, 'h50);
        wr(0, 'h60); wr(0, 'h77); look(0, 16'h00B0, "R11");
        wr(0, 'h90); look(0, 16'h0DFE, "R11");
        wr(0, 'h50);
        // R7 lock again
        wr(0, 'h60); wr(0, 'h01); wait_ready(PC, "R7");
        wr(0, 'h90); look(0, 16'h0DFF, "R7");
        // R2 array mode read of nonexistent sector
        wr(0, 'hFF); look(52, 16'hFFFF, "R2");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule